// File: doc/BRIEF.md
# Coprocessor-2 Move Unit

This block executes the register-transfer instructions of coprocessor 2 in one stage of a 64-bit MIPS-style pipeline. The rest of the pipeline presents a 32-bit instruction word together with a valid strobe. It also supplies the coprocessor-2 usable bit from the status register and the 64-bit value of the source general register. The block then returns, one clock later, either a general-register write (index, data, enable) or an exception request that carries a cause code and a coprocessor number.

Coprocessor 2 has no real datapath here. A single 64-bit latch stands in for its whole register file. Every register number reads and writes that same latch. A move into coprocessor 2 stores the full 64-bit source value. A move out returns either the full value or its low word sign-extended. Arithmetic, the general register file and exception vectoring live elsewhere.

Top module: `cp2x_move_unit`

## Requirements
- R1: The format field is instruction bits [25:21] and the target general register rt is bits [20:16]. The assigned formats are 0 word-read, 1 doubleword-read, 2 control-read, 4 word-write, 5 doubleword-write and 6 control-write.
- R2: With the usable bit clear, any valid instruction raises an exception with cause 11 and coprocessor number 2. It makes no general-register write and leaves the latch unchanged.
- R3: With the usable bit set, any unassigned format (3, 7, 8, 9 and 10 through 31) raises an exception with cause 10 and coprocessor number 2. It makes no write and leaves the latch unchanged.
- R4: Word-read and control-read write the latch's low 32 bits, sign-extended to 64 bits, to general register rt.
- R5: Doubleword-read writes all 64 latch bits to general register rt.
- R6: All three write formats store the full 64-bit source value into the latch. The register-number field (bits [15:11]) has no effect on where the value goes.
- R7: Reads return the shared latch whatever the register-number field holds.
- R8: Reset clears the latch, the write enable and the exception request.
- R9: Results appear on the outputs exactly one clock after the valid strobe, as one-cycle pulses. A read in the cycle right after a write returns the newly written value.
- R10: A read that targets general register 0 leaves the write enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_vld | input | 1 | Coprocessor-2 instruction valid strobe |
| instr | input | 32 | Instruction word |
| cu2_en | input | 1 | Coprocessor-2 usable bit |
| rt_val | input | 64 | Source general-register value |
| gpr_we | output | 1 | General-register write enable pulse |
| gpr_idx | output | 5 | General-register write index |
| gpr_wdata | output | 64 | General-register write data |
| exc_req | output | 1 | Exception request pulse |
| exc_cause | output | 5 | Exception cause code |
| exc_cop | output | 2 | Coprocessor number of the exception |

## Verification
Reads are tried against latch values whose bit 31 is both clear and set. This separates correct sign-extension from zero-extension, and separates word reads from the doubleword read. Writes and reads use register numbers that differ from one another, which shows whether the register number is really ignored. The same format codes are sent once with the usable bit clear and once with it set, along with several unassigned codes. Follow-up reads then show that neither exception kind disturbs the latch. A write followed at once by a read, and reads that target register 0, cover the forwarding timing and the suppressed write.

// File: rtl/cp2x_pkg.sv
package cp2x_pkg;
  localparam int unsigned XLEN     = 64;
  localparam int unsigned ILEN     = 32;
  localparam int unsigned FMT_W    = 5;
  localparam int unsigned REG_W    = 5;
  localparam int unsigned CAUSE_W  = 5;
  localparam int unsigned COP_W    = 2;
  localparam int unsigned FMT_LSB  = 21;
  localparam int unsigned RT_LSB   = 16;

  localparam logic [CAUSE_W-1:0] CAUSE_CPU = 5'd11;
  localparam logic [CAUSE_W-1:0] CAUSE_RI  = 5'd10;
  localparam logic [COP_W-1:0]   COP_NUM   = 2'd2;

  typedef enum logic [FMT_W-1:0] {
    FMT_RD_W  = 5'd0,
    FMT_RD_D  = 5'd1,
    FMT_RD_C  = 5'd2,
    FMT_WR_W  = 5'd4,
    FMT_WR_D  = 5'd5,
    FMT_WR_C  = 5'd6
  } fmt_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_READ32,
    K_READ64,
    K_WRITE,
    K_UNUSABLE,
    K_RESERVED
  } kind_e;
endpackage

// File: rtl/cp2x_decode.sv
module cp2x_decode
  import cp2x_pkg::*;
(
  input  logic             vld,
  input  logic [ILEN-1:0]  instr,
  input  logic             cu2_en,
  output kind_e            kind,
  output logic [REG_W-1:0] rt
);
  logic [FMT_W-1:0] fmt;

  assign fmt = instr[FMT_LSB +: FMT_W];
  assign rt  = instr[RT_LSB +: REG_W];

  always_comb begin
    kind = K_NONE;
    if (vld) begin
      if (!cu2_en) begin
        kind = K_UNUSABLE;
      end else begin
        case (fmt)
          FMT_RD_W, FMT_RD_C:           kind = K_READ32;
          FMT_RD_D:                     kind = K_READ64;
          FMT_WR_W, FMT_WR_D, FMT_WR_C: kind = K_WRITE;
          default:                      kind = K_RESERVED;
        endcase
      end
    end
  end
endmodule

// File: rtl/cp2x_latch.sv
module cp2x_latch
  import cp2x_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en) q_nxt = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/cp2x_move_unit.sv
module cp2x_move_unit
  import cp2x_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                instr_vld,
  input  logic [ILEN-1:0]     instr,
  input  logic                cu2_en,
  input  logic [XLEN-1:0]     rt_val,
  output logic                gpr_we,
  output logic [REG_W-1:0]    gpr_idx,
  output logic [XLEN-1:0]     gpr_wdata,
  output logic                exc_req,
  output logic [CAUSE_W-1:0]  exc_cause,
  output logic [COP_W-1:0]    exc_cop
);
  localparam int unsigned HALF = XLEN / 2;

  kind_e             kind;
  logic [REG_W-1:0]  rt;
  logic [XLEN-1:0]   latch_q;
  logic              latch_wr;

  logic              we_nxt, exc_nxt;
  logic              data_en, exc_en;
  logic [REG_W-1:0]  idx_nxt;
  logic [XLEN-1:0]   wdata_nxt;
  logic [CAUSE_W-1:0] cause_nxt;

  cp2x_decode u_dec (
    .vld    (instr_vld),
    .instr  (instr),
    .cu2_en (cu2_en),
    .kind   (kind),
    .rt     (rt)
  );

  cp2x_latch #(.W(XLEN)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (latch_wr),
    .wr_data (rt_val),
    .q       (latch_q)
  );

  assign latch_wr = (kind == K_WRITE);

  always_comb begin
    we_nxt    = 1'b0;
    exc_nxt   = 1'b0;
    data_en   = 1'b0;
    exc_en    = 1'b0;
    idx_nxt   = gpr_idx;
    wdata_nxt = gpr_wdata;
    cause_nxt = exc_cause;
    case (kind)
      K_READ32: begin
        data_en   = 1'b1;
        we_nxt    = (rt != '0);
        idx_nxt   = rt;
        wdata_nxt = {{HALF{latch_q[HALF-1]}}, latch_q[HALF-1:0]};
      end
      K_READ64: begin
        data_en   = 1'b1;
        we_nxt    = (rt != '0);
        idx_nxt   = rt;
        wdata_nxt = latch_q;
      end
      K_UNUSABLE: begin
        exc_en    = 1'b1;
        exc_nxt   = 1'b1;
        cause_nxt = CAUSE_CPU;
      end
      K_RESERVED: begin
        exc_en    = 1'b1;
        exc_nxt   = 1'b1;
        cause_nxt = CAUSE_RI;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpr_we  <= 1'b0;
      exc_req <= 1'b0;
    end else begin
      gpr_we  <= we_nxt;
      exc_req <= exc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpr_idx   <= '0;
      gpr_wdata <= '0;
    end else if (data_en) begin
      gpr_idx   <= idx_nxt;
      gpr_wdata <= wdata_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_cause <= '0;
      exc_cop   <= '0;
    end else if (exc_en) begin
      exc_cause <= cause_nxt;
      exc_cop   <= COP_NUM;
    end
  end

  assert_unusable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(instr_vld && !cu2_en) |-> (exc_req && exc_cause == CAUSE_CPU && !gpr_we));

  assert_latch_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(instr_vld && !cu2_en) |-> (latch_q == $past(latch_q)));

  assert_cop_num_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_cop == COP_NUM && !gpr_we));

  assert_dword_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(instr_vld && cu2_en && instr[FMT_LSB +: FMT_W] == 5'd1 && instr[RT_LSB +: REG_W] != '0)
      |-> (gpr_we && gpr_wdata == $past(latch_q)));

  assert_write_stores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(instr_vld && cu2_en && (instr[FMT_LSB +: FMT_W] == 5'd4 || instr[FMT_LSB +: FMT_W] == 5'd5
          || instr[FMT_LSB +: FMT_W] == 5'd6)) |-> (latch_q == $past(rt_val) && !gpr_we && !exc_req));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(instr_vld) |-> (!gpr_we && !exc_req));

  assert_no_r0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we |-> (gpr_idx != '0));
endmodule

// File: tb/test_cp2x_move_unit.sv
module test_cp2x_move_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_vld;
  logic [31:0] instr;
  logic        cu2_en;
  logic [63:0] rt_val;
  logic        gpr_we;
  logic [4:0]  gpr_idx;
  logic [63:0] gpr_wdata;
  logic        exc_req;
  logic [4:0]  exc_cause;
  logic [1:0]  exc_cop;

  int vectors = 0;
  int miscompares = 0;

  logic [63:0] m_latch;
  logic        e_we, e_exc;
  logic [4:0]  e_idx, e_cause;
  logic [63:0] e_data;
  string       e_tag;

  always #5 clk = ~clk;

  cp2x_move_unit i_cp2x_move_unit (
    .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr(instr),
    .cu2_en(cu2_en), .rt_val(rt_val), .gpr_we(gpr_we), .gpr_idx(gpr_idx),
    .gpr_wdata(gpr_wdata), .exc_req(exc_req), .exc_cause(exc_cause), .exc_cop(exc_cop)
  );

  function automatic logic [31:0] mk(input logic [4:0] fmt, input logic [4:0] rt, input logic [4:0] rd);
    return {6'b010010, fmt, rt, rd, 11'd0};
  endfunction

  task automatic compare();
    bit bad = 0;
    vectors++;
    if (gpr_we !== e_we) begin
      bad = 1; $display("FAIL %s gpr_we act=%0b exp=%0b", e_tag, gpr_we, e_we);
    end
    if (exc_req !== e_exc) begin
      bad = 1; $display("FAIL %s exc_req act=%0b exp=%0b", e_tag, exc_req, e_exc);
    end
    if (e_we && (gpr_idx !== e_idx || gpr_wdata !== e_data)) begin
      bad = 1;
      $display("FAIL %s write act=%0d:%h exp=%0d:%h", e_tag, gpr_idx, gpr_wdata, e_idx, e_data);
    end
    if (e_exc && (exc_cause !== e_cause || exc_cop !== 2'd2)) begin
      bad = 1;
      $display("FAIL %s exc act=%0d/%0d exp=%0d/2", e_tag, exc_cause, exc_cop, e_cause);
    end
    if (bad) miscompares++;
  endtask

  // One vector: check the previous stimulus' result, then drive a new one
  task automatic step(input bit vld, input bit cu, input logic [4:0] fmt, input logic [4:0] rt,
                      input logic [4:0] rd, input logic [63:0] val, input string note);
    @(negedge clk);
    compare();
    instr_vld = vld; cu2_en = cu; instr = mk(fmt, rt, rd); rt_val = val;
    e_we = 0; e_exc = 0;
    if (!vld) e_tag = {note, " R9 idle"};
    else if (!cu) begin
      e_exc = 1; e_cause = 5'd11; e_tag = {note, " R2"};
    end else begin
      case (fmt)
        5'd0, 5'd2: begin
          e_we = (rt != 0); e_idx = rt;
          e_data = {{32{m_latch[31]}}, m_latch[31:0]};
          e_tag = {note, (rt == 0) ? " R10" : " R1 R4"};
        end
        5'd1: begin
          e_we = (rt != 0); e_idx = rt; e_data = m_latch;
          e_tag = {note, (rt == 0) ? " R10" : " R1 R5"};
        end
        5'd4, 5'd5, 5'd6: begin
          m_latch = val; e_tag = {note, " R1 R6"};
        end
        default: begin
          e_exc = 1; e_cause = 5'd10; e_tag = {note, " R3"};
        end
      endcase
    end
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 0; instr_vld = 0; cu2_en = 0; instr = 0; rt_val = 0;
    m_latch = 0; e_we = 0; e_exc = 0; e_idx = 0; e_cause = 0; e_data = 0;
    e_tag = "R8 reset";
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8: reset state, and latch cleared (read returns zero)
    step(1, 1, 5'd1, 5'd3, 5'd0, 64'h0, "R8");
    // R6, R7: write via rd=5, read via rd=17 and rd=31
    step(1, 1, 5'd4, 5'd0, 5'd5, 64'h1234_5678_7654_3210, "R6");
    step(1, 1, 5'd0, 5'd7, 5'd17, 64'h0, "R7 R9 back-to-back");
    step(1, 1, 5'd1, 5'd8, 5'd31, 64'h0, "R7");
    step(0, 1, 5'd0, 5'd8, 5'd0, 64'h0, "");
    // R4: negative low word
    step(1, 1, 5'd5, 5'd2, 5'd9, 64'h0000_0001_8000_00F0, "R6 dword");
    step(1, 1, 5'd0, 5'd9, 5'd1, 64'h0, "R4 neg");
    step(1, 1, 5'd2, 5'd10, 5'd2, 64'h0, "R4 ctl");
    step(1, 1, 5'd1, 5'd11, 5'd3, 64'h0, "R5");
    step(1, 1, 5'd6, 5'd4, 5'd30, 64'hFFFF_0000_7FFF_FFFF, "R6 ctl");
    step(1, 1, 5'd2, 5'd12, 5'd0, 64'h0, "R4 pos");
    // R10
    step(1, 1, 5'd0, 5'd0, 5'd4, 64'h0, "R10");
    step(1, 1, 5'd1, 5'd0, 5'd4, 64'h0, "R10");
    // R2: unusable across assigned and unassigned formats; latch must hold
    for (int f = 0; f < 10; f++) step(1, 0, 5'(f), 5'd13, 5'd1, 64'hDEAD_BEEF_DEAD_BEEF, "R2");
    step(1, 1, 5'd1, 5'd14, 5'd0, 64'h0, "R2 latch held");
    // R3: reserved formats; latch must hold
    step(1, 1, 5'd3, 5'd15, 5'd0, 64'hAAAA_AAAA_AAAA_AAAA, "R3");
    step(1, 1, 5'd7, 5'd15, 5'd0, 64'hAAAA_AAAA_AAAA_AAAA, "R3");
    step(1, 1, 5'd8, 5'd15, 5'd0, 64'hAAAA_AAAA_AAAA_AAAA, "R3");
    step(1, 1, 5'd9, 5'd15, 5'd0, 64'hAAAA_AAAA_AAAA_AAAA, "R3");
    for (int f = 10; f < 32; f++) step(1, 1, 5'(f), 5'd16, 5'd2, 64'h5555_5555_5555_5555, "R3");
    step(1, 1, 5'd1, 5'd17, 5'd0, 64'h0, "R3 latch held");
    // R9: pulse lasts a single cycle
    step(0, 1, 5'd1, 5'd17, 5'd0, 64'h0, "");
    step(0, 1, 5'd1, 5'd17, 5'd0, 64'h0, "");
    step(1, 1, 5'd4, 5'd1, 5'd0, 64'hCAFE_F00D_0BAD_C0DE, "R9");
    step(1, 1, 5'd1, 5'd18, 5'd6, 64'h0, "R9 back-to-back");
    step(0, 1, 5'd0, 5'd0, 5'd0, 64'h0, "");
    @(negedge clk);
    compare();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule